// File: doc/BRIEF.md
# Two-Way Latched Bus Transceiver

This block joins two 8-bit buses, called A and B, and can move data either way between them. Each direction has its own bank of storage latches and its own three active-low controls: a chip enable, a latch enable and an output enable. With the chip enable and the latch enable both low, the latch bank follows the source bus. When the latch enable rises, the latch bank keeps the last value it took and stops following the source bus. With the chip enable and the output enable both low, the destination bus drives the stored value without inversion. Otherwise the destination bus is released.

Each bus is brought out as three vectors: an input, an output and a per-bit output enable. A pad ring or a bus fabric combines them into a shared line. Each latch bank is a register gated by an enable on the system clock. In the default build, a value on the source bus reaches the latch one clock after it is sampled. A parameter can add a combinational path that passes the source straight through while the latch is open. A synchronous, active-high reset clears both latch banks and releases both buses.

Top module: `latched_xcvr`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are all zeros. After reset both latch banks hold 8'h00. So if a direction's output is enabled before any capture, it drives 8'h00, and input values present during reset are not kept.
- R2: If a direction's chip enable and latch enable are both low at a rising clock edge, that direction's latch takes the source bus value (`a_in` for A-to-B, `b_in` for B-to-A). The value is visible on the destination output after that edge.
- R3: While a direction's latch enable is high, its latch keeps its value whatever the source bus does. The last value taken before the latch enable rose is the value kept, including across periods when the output is disabled.
- R4: While a direction's chip enable is high, its latch keeps its value even if the latch enable is low. A latch-enable rise that happens while the chip enable is high captures nothing.
- R5: A destination enable vector (`b_oe` for A-to-B, `a_oe` for B-to-A) is all ones exactly when that direction's chip enable and output enable are both low and reset is low. In every other case it is all zeros; it is never partly set.
- R6: While a destination bus is enabled, its output vector equals that direction's latch contents bit for bit, with no inversion.
- R7: The two directions are independent. Loading, holding or enabling one direction never changes the other direction's latch contents or output.
- R8: When the control sequence does not enable both directions together, `a_oe` and `b_oe` are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value driven onto bus A (B-to-A latch) |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value driven onto bus B (A-to-B latch) |
| b_oe | output | 8 | Per-bit drive enable for bus B |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
A latch bank in the wrong state shows nothing while its output is disabled. The fault appears on the destination output in the first cycle that the output is enabled. For that reason, every hold and ignore case in the bench re-enables the output and reads the stored value there. A capture that is missed or arrives late shows up one clock after the edge that should have loaded it. Enable-gating faults show up in the same cycle as the control change, because the enables are combinational from the controls.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   localparam int XCVR_DIRS  = 2;
   localparam int XCVR_AB    = 0;
   localparam int XCVR_BA    = 1;

   // Active-low control triple of one direction
   typedef struct packed {
      logic ce_n;
      logic le_n;
      logic oe_n;
   } dir_ctrl_t;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int WIDTH  = 8,
   parameter bit BYPASS = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             ce_n,
   input  logic             le_n,
   output logic [WIDTH-1:0] view
);

   logic [WIDTH-1:0] q;
   logic             open_now;

   assign open_now = ~ce_n & ~le_n;

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (open_now)
         q <= din;
   end

   generate
      if (BYPASS) begin : g_flow
         assign view = open_now ? din : q;
      end else begin : g_reg
         assign view = q;
      end
   endgenerate

   // R1: a reset cycle leaves the bank cleared
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (q == '0));

   // R2: an open latch takes the source value
   assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (!ce_n && !le_n) |=> (q == $past(din)));

   // R3: latch enable high keeps the value
   assert_store_R3: assert property (@(posedge clk) disable iff (rst)
      le_n |=> $stable(q));

   // R4: chip enable high keeps the value
   assert_hold_ce_R4: assert property (@(posedge clk) disable iff (rst)
      ce_n |=> $stable(q));

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int WIDTH = 8
) (
   input  logic             rst,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] view,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] oe
);

   logic drive_on;

   assign drive_on = ~rst & ~ce_n & ~oe_n;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign oe[i]   = drive_on;
         assign dout[i] = view[i];
      end
   endgenerate

   // R5: the enables are all set or all clear
   always_comb begin
      assert_oe_whole_R5: assert (($countones(oe) == 0) || ($countones(oe) == WIDTH));
      if (rst)
         assert_reset_quiet_R1: assert (oe == '0);
   end

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
   import xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit BYPASS = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] src,
   input  dir_ctrl_t        ctrl,
   output logic [WIDTH-1:0] dout,
   output logic [WIDTH-1:0] oe
);

   logic [WIDTH-1:0] view;

   xcvr_store #(.WIDTH(WIDTH), .BYPASS(BYPASS)) i_store (
      .clk  (clk),
      .rst  (rst),
      .din  (src),
      .ce_n (ctrl.ce_n),
      .le_n (ctrl.le_n),
      .view (view)
   );

   xcvr_drive #(.WIDTH(WIDTH)) i_drive (
      .rst  (rst),
      .ce_n (ctrl.ce_n),
      .oe_n (ctrl.oe_n),
      .view (view),
      .dout (dout),
      .oe   (oe)
   );

   // R6: an enabled output carries the latch contents unchanged
   always_comb begin
      if (oe[0])
         assert_pass_true_R6: assert (dout == view);
   end

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
   import xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit BYPASS = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   input  logic             ab_ce_n,
   input  logic             ab_le_n,
   input  logic             ab_oe_n,
   input  logic             ba_ce_n,
   input  logic             ba_le_n,
   input  logic             ba_oe_n
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("latched_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] src_v  [XCVR_DIRS];
   logic [WIDTH-1:0] dout_v [XCVR_DIRS];
   logic [WIDTH-1:0] oe_v   [XCVR_DIRS];
   dir_ctrl_t        ctrl_v [XCVR_DIRS];

   assign src_v[XCVR_AB]  = a_in;
   assign src_v[XCVR_BA]  = b_in;
   assign ctrl_v[XCVR_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
   assign ctrl_v[XCVR_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};

   generate
      for (genvar d = 0; d < XCVR_DIRS; d++) begin : g_dir
         xcvr_dir #(.WIDTH(WIDTH), .BYPASS(BYPASS)) i_dir (
            .clk  (clk),
            .rst  (rst),
            .src  (src_v[d]),
            .ctrl (ctrl_v[d]),
            .dout (dout_v[d]),
            .oe   (oe_v[d])
         );
      end
   endgenerate

   assign b_out = dout_v[XCVR_AB];
   assign b_oe  = oe_v[XCVR_AB];
   assign a_out = dout_v[XCVR_BA];
   assign a_oe  = oe_v[XCVR_BA];

   // R7: B-to-A controls idle keeps bus A output steady
   assert_ba_isolated_R7: assert property (@(posedge clk) disable iff (rst)
      (ba_ce_n && $past(ba_ce_n) && !ba_oe_n && !$past(ba_oe_n) && !$past(rst)) |-> $stable(a_out));

endmodule

// File: tb/test_latched_xcvr.sv
module test_latched_xcvr;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
   logic       ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   latched_xcvr i_latched_xcvr (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
   );

   // {a_in, ab{ce,le,oe}, b_in, ba{ce,le,oe}, exp_b_on, exp_b, exp_a_on, exp_a}
   localparam int NV = 13;
   localparam logic [39:0] VEC [NV] = '{
      {8'h3C, 3'b000, 8'h00, 3'b111, 1'b1, 8'h3C, 1'b0, 8'h00}, // R2
      {8'hA5, 3'b000, 8'h00, 3'b111, 1'b1, 8'hA5, 1'b0, 8'h00}, // R2 R6
      {8'hFF, 3'b010, 8'h00, 3'b111, 1'b1, 8'hA5, 1'b0, 8'h00}, // R3
      {8'h12, 3'b011, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0, 8'h00}, // R5
      {8'h12, 3'b010, 8'h00, 3'b111, 1'b1, 8'hA5, 1'b0, 8'h00}, // R3
      {8'h77, 3'b100, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0, 8'h00}, // R4 R5
      {8'h77, 3'b110, 8'h00, 3'b111, 1'b0, 8'h00, 1'b0, 8'h00}, // R4
      {8'h77, 3'b010, 8'h00, 3'b111, 1'b1, 8'hA5, 1'b0, 8'h00}, // R4
      {8'h00, 3'b111, 8'h5A, 3'b000, 1'b0, 8'h00, 1'b1, 8'h5A}, // R2 R7
      {8'h00, 3'b111, 8'h81, 3'b000, 1'b0, 8'h00, 1'b1, 8'h81}, // R2
      {8'h00, 3'b111, 8'h00, 3'b010, 1'b0, 8'h00, 1'b1, 8'h81}, // R3
      {8'h9E, 3'b010, 8'hC3, 3'b110, 1'b1, 8'hA5, 1'b0, 8'h00}, // R7
      {8'h9E, 3'b111, 8'hC3, 3'b010, 1'b0, 8'h00, 1'b1, 8'h81}  // R7
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_ctrl(input logic [2:0] ab, input logic [2:0] ba);
      {ab_ce_n, ab_le_n, ab_oe_n} = ab;
      {ba_ce_n, ba_le_n, ba_oe_n} = ba;
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst = 1'b1;
      a_in = 8'hFF;
      b_in = 8'hEE;
      set_ctrl(3'b000, 3'b000);
      tick();
      check("R1 b_oe in reset", b_oe, 8'h00);
      check("R1 a_oe in reset", a_oe, 8'h00);
      tick();
      @(negedge clk);
      rst = 1'b0;
      set_ctrl(3'b010, 3'b111);
      tick();
      check("R1 A-to-B latch cleared", b_out, 8'h00);
      check("R5 b_oe on", b_oe, 8'hFF);
      @(negedge clk);
      set_ctrl(3'b111, 3'b010);
      tick();
      check("R1 B-to-A latch cleared", a_out, 8'h00);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         a_in = VEC[i][39:32];
         b_in = VEC[i][28:21];
         set_ctrl(VEC[i][31:29], VEC[i][20:18]);
         tick();
         check($sformatf("R5 b_oe vec %0d", i), b_oe, {8{VEC[i][17]}});
         check($sformatf("R5 a_oe vec %0d", i), a_oe, {8{VEC[i][8]}});
         if (VEC[i][17])
            check($sformatf("R6 b_out vec %0d", i), b_out, VEC[i][16:9]);
         if (VEC[i][8])
            check($sformatf("R6 a_out vec %0d", i), a_out, VEC[i][7:0]);
         check($sformatf("R8 contention vec %0d", i), {7'd0, (|a_oe) & (|b_oe)}, 8'h00);
      end

      // R4: latch-enable rise while chip enable high captures nothing
      @(negedge clk); a_in = 8'h44; set_ctrl(3'b101, 3'b111);
      tick();
      @(negedge clk); a_in = 8'h66; set_ctrl(3'b111, 3'b111);
      tick();
      @(negedge clk); set_ctrl(3'b010, 3'b111);
      tick();
      check("R4 le edge under ce high", b_out, 8'hA5);

      // R7: A-to-B load while B-to-A held
      @(negedge clk); a_in = 8'h0F; set_ctrl(3'b001, 3'b111);
      tick();
      @(negedge clk); set_ctrl(3'b111, 3'b010);
      tick();
      check("R7 B-to-A unaffected", a_out, 8'h81);
      @(negedge clk); set_ctrl(3'b010, 3'b111);
      tick();
      check("R2 hidden capture", b_out, 8'h0F);

      // R1: mid-run reset
      @(negedge clk); rst = 1'b1; a_in = 8'hEE; set_ctrl(3'b000, 3'b111);
      tick();
      check("R1 b_oe mid reset", b_oe, 8'h00);
      @(negedge clk); rst = 1'b0; set_ctrl(3'b010, 3'b111);
      tick();
      check("R1 A-to-B cleared after reset", b_out, 8'h00);
      @(negedge clk); set_ctrl(3'b111, 3'b010);
      tick();
      check("R1 B-to-A cleared after reset", a_out, 8'h00);

      finish_run();
   end

endmodule